// File: doc/BRIEF.md
# SD Card Command/Response Engine

This block handles the command path of an SD host. The host logic gives it a 6-bit command index, a 32-bit argument and a response kind, then pulses `start`. The engine builds a 48-bit command frame and appends a CRC7 that it computes bit by bit. It shifts the frame out on the CMD line against a card clock that it generates itself. When the frame has been sent, the engine releases CMD and waits for the card to pull the line low. It then captures a short reply of 48 bits or a long reply of 136 bits, checks the reply and reports one of four outcomes.

Short replies are checked for their CRC and for the echoed command index. Index 41 is exempt from the echo check. Long replies must start with the header byte 0x3F, and their CRC covers only the fifteen bytes after that header. A command that expects no reply completes as soon as its frame is out. A reply that is not complete within a configurable number of system clock cycles ends the command with a timeout.

The host sees `busy` while a command is in flight. It then sees a single-cycle `done` together with `status` and `rsp_data`.

Top module: `sdcmd_engine`

## Requirements
- R1: A command frame is 48 bits long and is sent most significant bit first: bit 0, then bit 1, then the 6-bit index, then the 32-bit argument, then the 7-bit CRC, then a final 1. `cmd_oe` is high for exactly those 48 bit periods, and `cmd_o` changes only when `sd_clk` falls.
- R2: The frame CRC7 uses the polynomial x^7+x^3+1, starts from zero and covers the first 40 bits of the frame.
- R3: `sd_clk` starts low after reset and toggles every `CLK_DIV` system clock cycles. It runs freely.
- R4: `rsp_kind` is encoded as follows: 00 means no response, 01 means a 48-bit response, and 1x means a 136-bit response. With 00, `done` rises with status OK in the same cycle in which `cmd_oe` falls.
- R5: After the frame, the engine samples CMD on rising edges of `sd_clk`. The first 0 is bit 0 of the reply. For a short reply, the CRC7 of reply bits 47..8 is compared with bits 7..1. A mismatch gives status 2 (CRC error).
- R6: If a short reply carries a CRC that is valid but its bits 45..40 differ from the issued index, the status is 3 (response code error). The one exception is issued index 41, which gives status 0. For a short reply, `rsp_data[31:0]` holds reply bits 39..8 and the upper 96 bits are zero.
- R7: A long reply has 136 bits. Its CRC7 over bits 127..8 is compared with bits 7..1, and a mismatch gives status 2. If the CRC is good but the leading byte (bits 135..128) is not 0x3F, the status is 3. A CRC error takes precedence over a header error. `rsp_data` holds reply bits 127..0.
- R8: If the reply is not complete within `TIMEOUT_CYCLES` system cycles after `cmd_oe` falls, `done` rises exactly `TIMEOUT_CYCLES` cycles after that fall, with status 1 (timeout).
- R9: `done` is a pulse one cycle wide. For a command with a reply, `done` rises one system cycle after the `sd_clk` rising edge that samples the last reply bit. `busy` is high from the cycle after `start` is accepted until `done`, and it is low afterwards.
- R10: A `start` pulse is ignored while `busy` is high. No second frame is sent and the first command is not disturbed.
- R11: While reset is asserted, `busy`, `done`, `cmd_oe`, `status` and `rsp_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue a command (taken only when idle) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_kind | input | 2 | 00 no reply, 01 short reply, 1x long reply |
| busy | output | 1 | A command is in flight |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 OK, 1 timeout, 2 CRC error, 3 response code error |
| rsp_data | output | 128 | Reply payload |
| sd_clk | output | 1 | Generated card clock |
| cmd_o | output | 1 | CMD value driven by the host |
| cmd_oe | output | 1 | CMD output enable |
| cmd_i | input | 1 | CMD line as seen at the pin |

## Verification
Each result has its own due time. `busy` is due one system cycle after `start`. A no-reply completion is due in the same cycle as the release of CMD. A checked reply is due one cycle after the `sd_clk` rise that samples its last bit, and the bench reads that rise time from its own card model. A timeout is due exactly `TIMEOUT_CYCLES` cycles after the release of CMD. The bench samples at falling system clock edges, measures each of these distances in time units, and compares them with the exact value. The card clock phase is compared against a behavioural count on every cycle.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int CMD_BITS    = 48;
  localparam int LONG_BITS   = 136;
  localparam int BODY_BITS   = 40;
  localparam logic [5:0] ECHO_EXEMPT = 6'd41;
  localparam logic [7:0] LONG_HEADER = 8'h3F;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_TIMEOUT  = 2'd1,
    ST_CRC_ERR  = 2'd2,
    ST_CODE_ERR = 2'd3
  } status_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SEND, PH_WAIT, PH_RECV, PH_CHECK
  } phase_e;

  // One serial step of the x^7+x^3+1 register.
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  // Frame skeleton: CRC field left zero, end bit set.
  function automatic logic [47:0] frame_skeleton(input logic [5:0] idx, input logic [31:0] arg);
    return {2'b01, idx, arg, 7'd0, 1'b1};
  endfunction

  function automatic logic [7:0] reply_len(input logic is_long);
    return is_long ? 8'(LONG_BITS) : 8'(CMD_BITS);
  endfunction

  // Which received bit positions (0 = first on the wire) enter the CRC.
  function automatic logic crc_covers(input logic is_long, input logic [7:0] pos);
    if (is_long) return (pos >= 8'd8) && (pos < 8'd128);
    return pos < 8'(BODY_BITS);
  endfunction

  function automatic status_e judge_reply(input logic is_long, input logic [135:0] rx,
                                          input logic [6:0] crc, input logic [5:0] idx);
    if (rx[7:1] != crc) return ST_CRC_ERR;
    if (is_long) return (rx[135:128] == LONG_HEADER) ? ST_OK : ST_CODE_ERR;
    if ((rx[45:40] != idx) && (idx != ECHO_EXEMPT)) return ST_CODE_ERR;
    return ST_OK;
  endfunction

  function automatic logic [127:0] reply_payload(input logic is_long, input logic [135:0] rx);
    return is_long ? rx[127:0] : {96'd0, rx[39:8]};
  endfunction

endpackage

// File: rtl/sdcmd_clkgen.sv
module sdcmd_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic sd_clk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt;
  logic         wrap;

  assign wrap      = (cnt == W'(DIV - 1));
  assign rise_tick = wrap && !sd_clk;
  assign fall_tick = wrap && sd_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sd_clk <= 1'b0;
    end else if (wrap) begin
      cnt    <= '0;
      sd_clk <= ~sd_clk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       feed,
  input  logic       shift_out,
  input  logic       bit_in,
  output logic [6:0] crc
);
  import sdcmd_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         crc <= '0;
    else if (clr)       crc <= '0;
    else if (shift_out) crc <= {crc[5:0], 1'b0};
    else if (feed)      crc <= crc7_step(crc, bit_in);
  end
endmodule

// File: rtl/sdcmd_tmo.sv
module sdcmd_tmo #(
  parameter int LIMIT = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  assign expired = run && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine #(
  parameter int CLK_DIV        = 4,
  parameter int TIMEOUT_CYCLES = 500000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [5:0]   cmd_index,
  input  logic [31:0]  cmd_arg,
  input  logic [1:0]   rsp_kind,
  output logic         busy,
  output logic         done,
  output logic [1:0]   status,
  output logic [127:0] rsp_data,
  output logic         sd_clk,
  output logic         cmd_o,
  output logic         cmd_oe,
  input  logic         cmd_i
);
  import sdcmd_pkg::*;

  logic rise_tick, fall_tick;

  sdcmd_clkgen #(.DIV(CLK_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .sd_clk(sd_clk),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  phase_e         ph;
  logic [47:0]    tx_sh;
  logic [5:0]     tx_n;
  logic [135:0]   rx_sh;
  logic [7:0]     rx_n;
  logic [5:0]     idx_q;
  logic [1:0]     kind_q;
  logic           is_long, no_rsp;

  // Named internal events (also used by the checker).
  logic frame_sent, rx_take, rx_last, tmo_expired, tmo_run;

  assign is_long    = kind_q[1];
  assign no_rsp     = (kind_q == 2'b00);
  assign busy       = (ph != PH_IDLE);
  assign frame_sent = (ph == PH_SEND) && fall_tick && (tx_n == 6'(CMD_BITS));
  assign rx_take    = rise_tick && (((ph == PH_WAIT) && !cmd_i) || (ph == PH_RECV));
  assign rx_last    = rx_take && (rx_n == reply_len(is_long) - 8'd1);
  assign tmo_run    = (ph == PH_WAIT) || (ph == PH_RECV);

  sdcmd_tmo #(.LIMIT(TIMEOUT_CYCLES)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run(tmo_run), .expired(tmo_expired)
  );

  logic       crc_clr, crc_feed, crc_shift, crc_bit;
  logic [6:0] crc_val;

  always_comb begin
    crc_clr   = ((ph == PH_IDLE) && start) || frame_sent;
    crc_shift = (ph == PH_SEND) && fall_tick && (tx_n >= 6'(BODY_BITS)) && (tx_n < 6'd47);
    crc_feed  = ((ph == PH_SEND) && fall_tick && (tx_n < 6'(BODY_BITS)))
              || (rx_take && !tmo_expired && crc_covers(is_long, rx_n));
    crc_bit   = (ph == PH_SEND) ? tx_sh[47] : cmd_i;
  end

  sdcmd_crc7 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .feed(crc_feed),
    .shift_out(crc_shift), .bit_in(crc_bit), .crc(crc_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      tx_sh    <= '0;
      tx_n     <= '0;
      rx_sh    <= '0;
      rx_n     <= '0;
      idx_q    <= '0;
      kind_q   <= '0;
      done     <= 1'b0;
      status   <= ST_OK;
      rsp_data <= '0;
      cmd_o    <= 1'b1;
      cmd_oe   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: if (start) begin
          idx_q  <= cmd_index;
          kind_q <= rsp_kind;
          tx_sh  <= frame_skeleton(cmd_index, cmd_arg);
          tx_n   <= '0;
          ph     <= PH_SEND;
        end
        PH_SEND: if (fall_tick) begin
          if (tx_n < 6'(BODY_BITS)) begin
            cmd_o  <= tx_sh[47];
            cmd_oe <= 1'b1;
            tx_sh  <= {tx_sh[46:0], 1'b0};
          end else if (tx_n < 6'd47) begin
            cmd_o <= crc_val[6];
          end else if (tx_n == 6'd47) begin
            cmd_o <= 1'b1;
          end
          if (frame_sent) begin
            cmd_oe <= 1'b0;
            cmd_o  <= 1'b1;
            rx_n   <= '0;
            if (no_rsp) begin
              ph     <= PH_IDLE;
              done   <= 1'b1;
              status <= ST_OK;
            end else begin
              ph <= PH_WAIT;
            end
          end else begin
            tx_n <= tx_n + 1'b1;
          end
        end
        PH_WAIT, PH_RECV: begin
          if (tmo_expired) begin
            ph     <= PH_IDLE;
            done   <= 1'b1;
            status <= ST_TIMEOUT;
          end else if (rx_take) begin
            rx_sh <= {rx_sh[134:0], cmd_i};
            rx_n  <= rx_n + 1'b1;
            ph    <= rx_last ? PH_CHECK : PH_RECV;
          end
        end
        PH_CHECK: begin
          status   <= judge_reply(is_long, rx_sh, crc_val, idx_q);
          rsp_data <= reply_payload(is_long, rx_sh);
          done     <= 1'b1;
          ph       <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] status,
  input logic       cmd_o,
  input logic       cmd_oe,
  input logic       frame_sent,
  input logic       no_rsp,
  input logic       tmo_expired
);
  // R1: the first driven bit is the start bit 0
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_o);

  // R1: CMD is released after the last frame bit
  a_r1_release: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sent |=> !cmd_oe);

  // R9: CMD is only driven while a command is in flight
  a_r9_oe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy);

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: a command without a reply completes when the frame is out
  a_r4_no_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sent && no_rsp) |=> (done && status == 2'd0 && !busy));

  // R8: an expired wait ends with a timeout
  a_r8_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_expired |=> (done && status == 2'd1));

  // R10: busy only rises on an accepted start
  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .status(status), .cmd_o(cmd_o), .cmd_oe(cmd_oe), .frame_sent(frame_sent),
  .no_rsp(no_rsp), .tmo_expired(tmo_expired)
);

// File: tb/test_sdcmd_engine.sv
`timescale 1ns/1ps
module test_sdcmd_engine;
  localparam int DIV  = 2;
  localparam int TMO  = 1500;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [5:0]   cmd_index = '0;
  logic [31:0]  cmd_arg = '0;
  logic [1:0]   rsp_kind = '0;
  logic         busy, done, sd_clk, cmd_o, cmd_oe;
  logic [1:0]   status;
  logic [127:0] rsp_data;
  logic         card_drive = 1'b0;
  logic         card_bit = 1'b1;
  logic         cmd_line;

  assign cmd_line = cmd_oe ? cmd_o : (card_drive ? card_bit : 1'b1);

  always #2 clk = ~clk;

  sdcmd_engine #(.CLK_DIV(DIV), .TIMEOUT_CYCLES(TMO)) i_sdcmd_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .rsp_kind(rsp_kind), .busy(busy), .done(done),
    .status(status), .rsp_data(rsp_data), .sd_clk(sd_clk), .cmd_o(cmd_o),
    .cmd_oe(cmd_oe), .cmd_i(cmd_line)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int edges  = 0;
  bit in_cmd = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference CRC7 by long division (message followed by seven zeros).
  function automatic logic [6:0] ref_crc(input logic [127:0] v, input int n);
    logic [7:0] r = 8'd0;
    for (int i = n + 6; i >= 0; i--) begin
      r = {r[6:0], (i >= 7) ? v[i-7] : 1'b0};
      if (r[7]) r = r ^ 8'h89;
    end
    return r[6:0];
  endfunction

  function automatic logic [119:0] long_body(input logic [31:0] a);
    return {a, ~a, {a[15:0], a[31:16]}, a[23:0]};
  endfunction

  // Card clock reference (R3) compared every cycle; stray done check (R9).
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) edges = 0; else edges++;
  end
  always @(negedge clk) begin
    if (rst_n) begin
      check(sd_clk == ((edges / DIV) % 2), "R3", "sd_clk phase", 128'(sd_clk), 128'((edges / DIV) % 2));
      if (done && !in_cmd) check(0, "R9", "done outside a command", 1, 0);
    end
  end

  // Watchdog
  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Card model
  int           card_mode = 0;
  int           frames_seen = 0;
  logic [47:0]  last_frame;
  time          t_last_rise = 0;

  initial begin
    forever begin
      logic [47:0]  f;
      logic [135:0] rv;
      logic [39:0]  sb;
      int           nb;
      do @(posedge sd_clk); while (!cmd_oe);
      f = {47'd0, cmd_o};
      for (int i = 1; i < 48; i++) begin
        @(posedge sd_clk);
        f = {f[46:0], cmd_o};
      end
      frames_seen++;
      last_frame = f;
      nb = 0;
      rv = '0;
      if (card_mode >= 1 && card_mode <= 3) begin
        sb = {2'b00, (card_mode == 3) ? (f[45:40] ^ 6'd1) : f[45:40], f[39:8] ^ 32'h1357_9BDF};
        rv = {88'd0, sb, ref_crc(128'(sb), 40) ^ ((card_mode == 2) ? 7'h01 : 7'h00), 1'b1};
        nb = 48;
      end else if (card_mode >= 4) begin
        rv = {(card_mode == 5 || card_mode == 7) ? 8'h3E : 8'h3F, long_body(f[39:8]),
              ref_crc(128'(long_body(f[39:8])), 120) ^ ((card_mode >= 6) ? 7'h40 : 7'h00), 1'b1};
        nb = 136;
      end
      if (nb > 0) begin
        repeat (2) @(negedge sd_clk);
        for (int i = nb - 1; i >= 0; i--) begin
          @(negedge sd_clk);
          card_drive = 1'b1;
          card_bit   = rv[i];
        end
        @(posedge sd_clk);
        t_last_rise = $time;
        @(negedge sd_clk);
        card_drive = 1'b0;
        card_bit   = 1'b1;
      end
    end
  end

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind,
                         input int mode, input logic [1:0] exp_st, input bit dup);
    logic [47:0]  exp_frame;
    logic [127:0] exp_data;
    int           seen0;
    time          t_rel, t_done;
    bit           prev_oe;
    int           w;
    seen0     = frames_seen;
    card_mode = mode;
    exp_frame = {2'b01, idx, arg, ref_crc(128'({2'b01, idx, arg}), 40), 1'b1};
    in_cmd    = 1;
    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; rsp_kind = kind; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9", "busy after start", 128'(busy), 1);
    if (dup) begin
      cmd_index = idx ^ 6'h0F; cmd_arg = ~arg; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    prev_oe = cmd_oe; t_rel = 0; w = 0;
    while (!done && w < 6000) begin
      @(negedge clk);
      if (prev_oe && !cmd_oe) t_rel = $time;
      prev_oe = cmd_oe;
      w++;
    end
    t_done = $time;
    check(done == 1'b1, "R9", "done seen", 128'(done), 1);
    check(status == exp_st, (mode == 0 && kind != 0) ? "R8" : (kind[1] ? "R7" : "R6"),
          "status", 128'(status), 128'(exp_st));
    check(frames_seen == seen0 + 1, dup ? "R10" : "R1", "frame count",
          128'(frames_seen - seen0), 1);
    check(last_frame == exp_frame, "R2", "frame bits with CRC7", 128'(last_frame), 128'(exp_frame));
    if (kind == 2'b00)
      check(t_done == t_rel, "R4", "no-reply completion time", 128'(t_done - t_rel), 0);
    else if (mode == 0)
      check(t_done - t_rel == TMO * 4, "R8", "timeout latency ns", 128'(t_done - t_rel), 128'(TMO * 4));
    else
      check(t_done - t_last_rise == 6, "R9", "done after last sample ns", 128'(t_done - t_last_rise), 6);
    if (exp_st == 2'd0 && kind != 2'b00) begin
      if (kind[1]) exp_data = {long_body(arg), ref_crc(128'(long_body(arg)), 120), 1'b1};
      else         exp_data = {96'd0, arg ^ 32'h1357_9BDF};
      check(rsp_data == exp_data, kind[1] ? "R7" : "R6", "payload", rsp_data, exp_data);
    end
    @(negedge clk);
    check(!done && !busy, "R9", "done/busy low after pulse", {busy, done}, 0);
    in_cmd = 0;
    repeat (30) @(negedge clk);
    check(frames_seen == seen0 + 1 && !cmd_oe, "R10", "no extra frame", 128'(frames_seen - seen0), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && cmd_oe == 0 && status == 0 && rsp_data == 0,
          "R11", "reset state", {busy, done, cmd_oe, status}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run_cmd(6'd17, 32'h0000_00A5, 2'b01, 1, 2'd0, 0);   // R5 R6 short ok
    run_cmd(6'd0,  32'h0000_0000, 2'b00, 0, 2'd0, 0);   // R4 none
    run_cmd(6'd55, 32'hFFFF_FFFF, 2'b01, 1, 2'd0, 0);   // R1 all-ones arg
    run_cmd(6'd13, 32'h8000_0001, 2'b01, 2, 2'd2, 0);   // R5 bad CRC
    run_cmd(6'd16, 32'h0000_0200, 2'b01, 3, 2'd3, 0);   // R6 wrong echo
    run_cmd(6'd41, 32'h40FF_8000, 2'b01, 3, 2'd0, 0);   // R6 exempt index
    run_cmd(6'd2,  32'hDEAD_BEEF, 2'b10, 4, 2'd0, 0);   // R7 long ok
    run_cmd(6'd9,  32'h1234_5678, 2'b11, 5, 2'd3, 0);   // R7 bad header
    run_cmd(6'd10, 32'h0F0F_0F0F, 2'b10, 6, 2'd2, 0);   // R7 bad CRC
    run_cmd(6'd9,  32'hCAFE_0000, 2'b10, 7, 2'd2, 0);   // R7 CRC precedence
    run_cmd(6'd8,  32'h0000_01AA, 2'b01, 0, 2'd1, 0);   // R8 short timeout
    run_cmd(6'd2,  32'h0000_0000, 2'b11, 0, 2'd1, 0);   // R8 long timeout
    run_cmd(6'd24, 32'h0000_1000, 2'b01, 1, 2'd0, 1);   // R10 start while busy
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule